// File: doc/BRIEF.md
# Nonvolatile Array Refresh Sequencer

This block walks a byte-addressable nonvolatile data array and rewrites every location with the value it already holds. The aim is to restore charge margin on cells that are rarely written. It acts as the host of a guarded write controller. For each byte it issues a read, captures the returned data, writes the two unlock codes to the controller's unlock register, and starts the write. It then polls the controller's busy flag until the write has completed.

A one-cycle start pulse launches the pass. The sequencer clears its split low/high address counter, selects the data space and requests that interrupts be masked. It then sets write-enable and leaves it set for the whole pass. When the last location has been rewritten, it drops write-enable and the interrupt mask together and pulses done. A write error reported by the controller cuts the pass short, releases both flags and raises a sticky failure flag.

Top module: `nv_refresh_seq`

## Requirements
- R1: After reset, busy_o, done_o, fail_o, wr_en_o, irq_mask_o, data_sel_o and all request strobes are low.
- R2: A start pulse in idle is followed by one setup cycle. In that cycle the address reads 0, data_sel_o and irq_mask_o are high and wr_en_o is still low. wr_en_o is high from the next cycle, which is the first read.
- R3: For each location the strobes come in this order: rd_req_o; unlock_we_o with unlock_data_o = 0x55; unlock_we_o with 0xAA; wr_start_o. The sequencer samples rd_data_i in the cycle after rd_req_o, and wr_data_o carries that byte while wr_start_o is high.
- R4: After wr_start_o the sequencer issues no further strobe while wr_busy_i is high. The controller must hold wr_busy_i high from the cycle after wr_start_o until the write ends.
- R5: The address starts at 0. addr_lo_o increments after each location. addr_hi_o increments only when addr_lo_o wraps from 0xFF to 0x00, so the address advances by exactly one at each step.
- R6: The pass ends after location ARRAY_BYTES-1; for the default of 65536 bytes this is when both address bytes wrap. In the done_o cycle, wr_en_o and irq_mask_o are already low, and done_o is high for exactly one cycle.
- R7: A start pulse while busy_o is high is ignored, and the pass continues with no address restart.
- R8: If wr_err_i is high while the sequencer waits for a write, the pass aborts. No further strobe is issued, wr_en_o and irq_mask_o drop, done_o pulses and fail_o rises in the done_o cycle. fail_o stays high until the next accepted start.
- R9: busy_o is high from the setup cycle through the done_o cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for a refresh pass |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle end-of-pass pulse |
| fail_o | output | 1 | Last pass aborted on a write error |
| irq_mask_o | output | 1 | Request to mask interrupts |
| data_sel_o | output | 1 | Select the data array (not configuration or program space) |
| wr_en_o | output | 1 | Write-enable to the controller |
| addr_lo_o | output | 8 | Low address byte |
| addr_hi_o | output | 8 | High address byte |
| rd_req_o | output | 1 | Read strobe |
| rd_data_i | input | 8 | Read data, valid the cycle after rd_req_o |
| unlock_we_o | output | 1 | Unlock register write strobe |
| unlock_data_o | output | 8 | Unlock code |
| wr_start_o | output | 1 | Write-start strobe |
| wr_data_o | output | 8 | Byte to write back |
| wr_busy_i | input | 1 | Write-start still set in the controller |
| wr_err_i | input | 1 | Controller write error |

## Verification
The bench runs a 300-byte configuration. It models the controller with a memory whose contents are computed from each address, and it varies the write latency from one location to the next. A clean pass over all 300 locations crosses the low-byte wrap. This shows whether the high byte carries correctly, whether each written byte matches the byte read, and whether the sequencer really waits on busy under different latencies. A start pulse injected mid-pass separates a sequencer that ignores it from one that restarts its address. An error injected at location 5 is followed by a clean pass. This shows whether the abort stops all strobes, releases both flags, and clears the failure flag on the next start.

// File: rtl/nv_refresh_pkg.sv
package nv_refresh_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_READ, S_CAPT, S_UNL1, S_UNL2, S_WSTART, S_WAIT, S_NEXT, S_END
  } seq_state_e;
  localparam logic [7:0] UNLOCK_FIRST  = 8'h55;
  localparam logic [7:0] UNLOCK_SECOND = 8'hAA;
endpackage

// File: rtl/nv_refresh_addr.sv
module nv_refresh_addr #(
  parameter int BYTE_W      = 8,
  parameter int ARRAY_BYTES = 65536
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              last_o
);
  localparam int ADDR_W = 2 * BYTE_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(ARRAY_BYTES - 1);

  logic [BYTE_W-1:0] lo_q, hi_q;
  logic              lo_wrap;

  assign lo_wrap = &lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (clr_i) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (inc_i) begin
      lo_q <= lo_q + 1'b1;
      if (lo_wrap) hi_q <= hi_q + 1'b1;  // carry only on low-byte wrap
    end
  end

  assign lo_o   = lo_q;
  assign hi_o   = hi_q;
  assign last_o = ({hi_q, lo_q} == LAST);
endmodule

// File: rtl/nv_refresh_fsm.sv
module nv_refresh_fsm
  import nv_refresh_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       wr_busy_i,
  input  logic       wr_err_i,
  input  logic       last_i,
  output seq_state_e state_o,
  output logic       ctr_clr_o,
  output logic       ctr_inc_o,
  output logic       wr_en_o,
  output logic       irq_mask_o,
  output logic       data_sel_o,
  output logic       fail_o
);
  seq_state_e state_q, state_d;
  logic wr_en_q, irq_q, sel_q, fail_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (start_i) state_d = S_SETUP;
      S_SETUP:  state_d = S_READ;
      S_READ:   state_d = S_CAPT;
      S_CAPT:   state_d = S_UNL1;
      S_UNL1:   state_d = S_UNL2;
      S_UNL2:   state_d = S_WSTART;
      S_WSTART: state_d = S_WAIT;
      S_WAIT: begin
        if (wr_err_i)        state_d = S_END;
        else if (!wr_busy_i) state_d = S_NEXT;
      end
      S_NEXT:   state_d = last_i ? S_END : S_READ;
      S_END:    state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      wr_en_q <= 1'b0;
      irq_q   <= 1'b0;
      sel_q   <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      case (state_q)
        S_IDLE: if (start_i) begin
          irq_q  <= 1'b1;
          sel_q  <= 1'b1;
          fail_q <= 1'b0;
        end
        S_SETUP: wr_en_q <= 1'b1;
        S_WAIT: if (wr_err_i) begin
          wr_en_q <= 1'b0;
          irq_q   <= 1'b0;
          fail_q  <= 1'b1;
        end
        S_NEXT: if (last_i) begin
          wr_en_q <= 1'b0;
          irq_q   <= 1'b0;
        end
        S_END: sel_q <= 1'b0;
        default: ;
      endcase
    end
  end

  assign state_o    = state_q;
  assign ctr_clr_o  = (state_q == S_IDLE) && start_i;
  assign ctr_inc_o  = (state_q == S_NEXT) && !last_i;
  assign wr_en_o    = wr_en_q;
  assign irq_mask_o = irq_q;
  assign data_sel_o = sel_q;
  assign fail_o     = fail_q;
endmodule

// File: rtl/nv_refresh_seq.sv
module nv_refresh_seq
  import nv_refresh_pkg::*;
#(
  parameter int ARRAY_BYTES = 65536,
  parameter int BYTE_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic              irq_mask_o,
  output logic              data_sel_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] addr_lo_o,
  output logic [BYTE_W-1:0] addr_hi_o,
  output logic              rd_req_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              unlock_we_o,
  output logic [BYTE_W-1:0] unlock_data_o,
  output logic              wr_start_o,
  output logic [BYTE_W-1:0] wr_data_o,
  input  logic              wr_busy_i,
  input  logic              wr_err_i
);
  seq_state_e state;
  logic ctr_clr, ctr_inc, last;
  logic [BYTE_W-1:0] data_q;

  nv_refresh_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .wr_busy_i  (wr_busy_i),
    .wr_err_i   (wr_err_i),
    .last_i     (last),
    .state_o    (state),
    .ctr_clr_o  (ctr_clr),
    .ctr_inc_o  (ctr_inc),
    .wr_en_o    (wr_en_o),
    .irq_mask_o (irq_mask_o),
    .data_sel_o (data_sel_o),
    .fail_o     (fail_o)
  );

  nv_refresh_addr #(.BYTE_W(BYTE_W), .ARRAY_BYTES(ARRAY_BYTES)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctr_clr),
    .inc_i  (ctr_inc),
    .lo_o   (addr_lo_o),
    .hi_o   (addr_hi_o),
    .last_o (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             data_q <= '0;
    else if (state == S_CAPT) data_q <= rd_data_i;
  end

  assign busy_o        = (state != S_IDLE);
  assign done_o        = (state == S_END);
  assign rd_req_o      = (state == S_READ);
  assign unlock_we_o   = (state == S_UNL1) || (state == S_UNL2);
  assign unlock_data_o = (state == S_UNL2) ? BYTE_W'(UNLOCK_SECOND) : BYTE_W'(UNLOCK_FIRST);
  assign wr_start_o    = (state == S_WSTART);
  assign wr_data_o     = data_q;
endmodule

// File: rtl/nv_refresh_checker.sv
module nv_refresh_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              fail_o,
  input logic              irq_mask_o,
  input logic              wr_en_o,
  input logic [BYTE_W-1:0] addr_lo_o,
  input logic [BYTE_W-1:0] addr_hi_o,
  input logic              unlock_we_o,
  input logic [BYTE_W-1:0] unlock_data_o,
  input logic              wr_start_o
);
  logic [2*BYTE_W-1:0] addr;
  assign addr = {addr_hi_o, addr_lo_o};

  assert_wren_masked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> irq_mask_o);

  assert_unlock_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlock_we_o && unlock_data_o == BYTE_W'(8'hAA)) |->
      $past(unlock_we_o && unlock_data_o == BYTE_W'(8'h55)));

  assert_start_after_unlock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start_o |-> $past(unlock_we_o && unlock_data_o == BYTE_W'(8'hAA)));

  assert_addr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_o) && busy_o && addr != $past(addr)) |-> addr == $past(addr) + 1'b1);

  assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_released_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!wr_en_o && !irq_mask_o));

  assert_fail_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> done_o);

  assert_done_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
endmodule

bind nv_refresh_seq nv_refresh_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .fail_o        (fail_o),
  .irq_mask_o    (irq_mask_o),
  .wr_en_o       (wr_en_o),
  .addr_lo_o     (addr_lo_o),
  .addr_hi_o     (addr_hi_o),
  .unlock_we_o   (unlock_we_o),
  .unlock_data_o (unlock_data_o),
  .wr_start_o    (wr_start_o)
);

// File: tb/nv_refresh_seq_test.sv
module nv_refresh_seq_test;
  localparam int N = 300;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic busy_o, done_o, fail_o, irq_mask_o, data_sel_o, wr_en_o;
  logic [7:0] addr_lo_o, addr_hi_o, unlock_data_o, wr_data_o;
  logic [7:0] rd_data_i = 8'h00;
  logic rd_req_o, unlock_we_o, wr_start_o;
  logic wr_busy_i = 1'b0, wr_err_i = 1'b0;

  int n_run = 0, n_bad = 0;
  int exp_addr = 0, phase = 0, n_wr = 0, n_done = 0, n_rd = 0;
  int busy_cnt = 0, cur_loc = 0, err_loc = -1;
  bit mon_on = 1'b0;

  always #10 clk = ~clk;

  nv_refresh_seq #(.ARRAY_BYTES(N)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
    .irq_mask_o(irq_mask_o), .data_sel_o(data_sel_o), .wr_en_o(wr_en_o),
    .addr_lo_o(addr_lo_o), .addr_hi_o(addr_hi_o),
    .rd_req_o(rd_req_o), .rd_data_i(rd_data_i),
    .unlock_we_o(unlock_we_o), .unlock_data_o(unlock_data_o),
    .wr_start_o(wr_start_o), .wr_data_o(wr_data_o),
    .wr_busy_i(wr_busy_i), .wr_err_i(wr_err_i)
  );

  function automatic logic [7:0] pat(int a);
    return 8'(a * 37 + 11);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // controller model and order monitor
  always @(negedge clk) if (mon_on) begin
    if (rd_req_o) begin
      n_rd++;
      chk(phase == 0 && !wr_busy_i, "R4 read after write done", phase, 0);
      chk({addr_hi_o, addr_lo_o} == 16'(exp_addr), "R5 address sequence",
          {addr_hi_o, addr_lo_o}, exp_addr);
      chk(wr_en_o && irq_mask_o && data_sel_o, "R2 flags during pass",
          {wr_en_o, irq_mask_o, data_sel_o}, 7);
      rd_data_i = pat({addr_hi_o, addr_lo_o});
      phase = 1;
    end
    if (unlock_we_o) begin
      if (phase == 1) begin
        chk(unlock_data_o == 8'h55, "R3 first unlock", unlock_data_o, 8'h55);
        phase = 2;
      end else if (phase == 2) begin
        chk(unlock_data_o == 8'hAA, "R3 second unlock", unlock_data_o, 8'hAA);
        phase = 3;
      end else chk(1'b0, "R3 unlock out of order", phase, 1);
    end
    if (wr_start_o) begin
      chk(phase == 3, "R3 write start after unlock", phase, 3);
      chk(wr_data_o == pat(exp_addr), "R3 write back data", wr_data_o, pat(exp_addr));
      cur_loc = exp_addr;
      exp_addr++;
      n_wr++;
      phase = 0;
      wr_busy_i = 1'b1;
      busy_cnt = 1 + (n_wr % 3);
    end else if (wr_busy_i) begin
      if (cur_loc == err_loc) wr_err_i = 1'b1;
      else begin
        busy_cnt--;
        if (busy_cnt == 0) wr_busy_i = 1'b0;
      end
    end
    if (done_o) begin
      n_done++;
      chk(!wr_en_o && !irq_mask_o, "R6 flags released at done",
          {wr_en_o, irq_mask_o}, 0);
      chk(busy_o, "R9 busy in done cycle", busy_o, 1);
      wr_err_i = 1'b0;
      wr_busy_i = 1'b0;
    end
  end

  task automatic launch();
    exp_addr = 0; phase = 0; n_wr = 0; n_done = 0; n_rd = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk({addr_hi_o, addr_lo_o} == 16'd0, "R2 address cleared", {addr_hi_o, addr_lo_o}, 0);
    chk(irq_mask_o && data_sel_o && !wr_en_o, "R2 setup cycle flags",
        {irq_mask_o, data_sel_o, wr_en_o}, 6);
    chk(busy_o, "R9 busy from setup", busy_o, 1);
    @(negedge clk);
    chk(wr_en_o && rd_req_o, "R2 write enable at first read", {wr_en_o, rd_req_o}, 3);
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !fail_o && !wr_en_o && !irq_mask_o && !data_sel_o,
        "R1 reset outputs", {busy_o, done_o, fail_o, wr_en_o, irq_mask_o, data_sel_o}, 0);
    chk(!rd_req_o && !unlock_we_o && !wr_start_o, "R1 reset strobes",
        {rd_req_o, unlock_we_o, wr_start_o}, 0);
    rst_ni = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);

    // clean pass with a stray start mid-pass
    launch();
    repeat (700) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o, "R7 start while busy ignored", busy_o, 1);
    wait_done();
    chk(n_wr == N, "R6 all locations rewritten", n_wr, N);
    chk(n_rd == N, "R7 no restart reads", n_rd, N);
    chk(n_done == 1, "R6 single done", n_done, 1);
    chk(!busy_o && !fail_o, "R6 idle after pass", {busy_o, fail_o}, 0);
    repeat (5) @(negedge clk);
    chk(n_rd == N && !busy_o, "R6 no strobes after end", n_rd, N);

    // aborted pass
    err_loc = 5;
    launch();
    wait_done();
    chk(fail_o, "R8 failure flagged", fail_o, 1);
    chk(n_wr == 6 && n_rd == 6, "R8 stop at error location", n_wr, 6);
    chk(!wr_en_o && !irq_mask_o && !busy_o, "R8 flags released",
        {wr_en_o, irq_mask_o, busy_o}, 0);
    repeat (5) @(negedge clk);
    chk(n_rd == 6 && fail_o, "R8 no strobes after abort, flag held", n_rd, 6);

    // recovery pass clears failure
    err_loc = -1;
    launch();
    chk(!fail_o, "R8 fail cleared by start", fail_o, 0);
    wait_done();
    chk(n_wr == N && !fail_o, "R5 recovery pass count", n_wr, N);
    chk(exp_addr == N, "R5 final address count", exp_addr, N);

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_run++;
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule